// File: doc/BRIEF.md
# Byte Stream to Wide SRAM Packer

The packer sits between a packet receiver that delivers one byte per clock and an SRAM whose word holds several bytes. It gathers bytes into words, earliest byte in the lowest lane, and writes each finished word to the SRAM at consecutive addresses. A burst from the receiver may end partway through a word. The bytes left over stay in the packer and are joined to the first bytes of the next burst. Data from back-to-back packets therefore lands in the SRAM as one unbroken stream, with no padding between packets.

The write side drives a shared SRAM port. It provides the data, the address, active-low chip-select and write-enable strobes, and a select line that claims the port for the packer. A start strobe begins a new load at address 0 and discards any held bytes. A flush strobe pushes out a held partial word with its unused lanes filled with zeros. The receiver is never stalled.

Top module: `byte_sram_packer`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_n_o` and `wen_n_o` are 1, `sel_o` is 0, and `wr_addr_o` and `wr_data_o` are 0.
- R2: In a written word, the k-th byte of the word in arrival order (k counting from 0) sits at bits 8k+7 down to 8k of `wr_data_o`.
- R3: A write is shown by `cs_n_o` and `wen_n_o` both being 0 for exactly one clock. That clock directly follows the edge that samples the byte completing the word. One byte is accepted on every clock where `byte_vld_i` is 1, with no back-pressure. At all other times both strobes are 1.
- R4: The first word after reset or a start is written at address 0. Each later word is written at the previous address plus 1, wrapping modulo 2^ADDR_W.
- R5: Bytes that do not fill a word are held for any number of idle cycles. No write happens until later bytes complete the word, and those later bytes fill the lanes directly above the held ones.
- R6: `start_i` empties the held bytes and returns the address to 0. A byte that is valid in the same cycle becomes lane 0 of the new load. A flush in the same cycle has no effect.
- R7: `flush_i` without a start writes the held bytes, including a byte that is valid in the same cycle, as one word with every unused lane 0, and then leaves the buffer empty. If nothing is held and no byte arrives, a flush causes no write. If the byte completes the word, only the normal single write occurs.
- R8: `sel_o` is 1 in every cycle where a write strobe is active or at least one byte is held after the last edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new load: empty the buffer, address back to 0 |
| flush_i | input | 1 | Write out a held partial word, zero-filled |
| byte_vld_i | input | 1 | `byte_i` carries a byte this clock |
| byte_i | input | 8 | Incoming byte |
| wr_data_o | output | 8*BPW | SRAM write data |
| wr_addr_o | output | ADDR_W | SRAM word address |
| wen_n_o | output | 1 | SRAM write enable, active low |
| cs_n_o | output | 1 | SRAM chip select, active low |
| sel_o | output | 1 | Claims the shared SRAM port |

## Verification
The bench sweeps burst lengths across word boundaries with idle gaps between bursts. A packer that padded or dropped the tail would shift every later byte into the wrong lane. It flushes at every fill level, with and without a byte arriving in the same cycle. Faults caught here include writing an empty word, skipping zero-fill, or writing twice when the flush byte completes the word. Starts are issued at every fill level, together with a byte and together with a flush, which exposes stale lanes and a wrong restart address. A long unbroken stream runs the address past its wrap, where an off-by-one or a missed wrap shows up at once.

// File: rtl/packer_pkg.sv
// Package: shared constants for the byte-to-word packer.
// Assumes bytes are 8 bits wide everywhere in the block.
package packer_pkg;
    localparam int unsigned BYTE_W = 8;

    // Width of a counter that must hold values 0..n-1 (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pack_lane_buf.sv
// Module: pack_lane_buf
// Collects bytes into word lanes, earliest byte in lane 0. It flags a word
// as ready once all lanes are filled, or on a flush while bytes are held.
// Assumes at most one byte per clock, and that start has priority over flush.
// Lanes are cleared whenever the buffer empties, so any lane not yet written
// reads as zero.
module pack_lane_buf
    import packer_pkg::*;
#(
    parameter int unsigned BPW = 4,
    localparam int unsigned WORD_W = BPW * BYTE_W,
    localparam int unsigned CNT_W = idx_width(BPW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              flush_i,
    input  logic              vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              emit_o,
    output logic [WORD_W-1:0] word_o,
    output logic              held_nxt_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] lanes_q;
    logic [CNT_W-1:0]  base_cnt;
    logic [WORD_W-1:0] base_lanes;
    logic [WORD_W-1:0] fill_lanes;
    logic [CNT_W:0]    fill_cnt;
    logic              full;
    logic              flush_hit;

    // Purpose: a start discards the held state before the byte is placed.
    always_comb begin
        base_cnt   = start_i ? '0 : cnt_q;
        base_lanes = start_i ? '0 : lanes_q;
    end

    // Purpose: drop the incoming byte into the first free lane.
    always_comb begin
        fill_lanes = base_lanes;
        for (int i = 0; i < int'(BPW); i++) begin
            if (vld_i && (base_cnt == CNT_W'(i)))
                fill_lanes[i*BYTE_W +: BYTE_W] = byte_i;
        end
    end

    // Purpose: decide whether a word leaves the buffer this cycle.
    always_comb begin
        fill_cnt   = {1'b0, base_cnt} + (CNT_W+1)'(vld_i);
        full       = (fill_cnt == (CNT_W+1)'(BPW));
        flush_hit  = flush_i && !start_i && (fill_cnt != '0);
        emit_o     = full || flush_hit;
        word_o     = fill_lanes;
        held_nxt_o = !emit_o && (fill_cnt != '0);
    end

    // Purpose: keep the held lanes and fill count, emptying on every emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lanes_q <= '0;
        end else if (emit_o) begin
            cnt_q   <= '0;
            lanes_q <= '0;
        end else begin
            cnt_q   <= fill_cnt[CNT_W-1:0];
            lanes_q <= fill_lanes;
        end
    end

    // R5: the held count never reaches a full word.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} < (CNT_W+1)'(BPW));

    // R6: a start with no byte leaves the buffer empty.
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !vld_i) |=> (cnt_q == '0));

    // R7: a flush without start always leaves the buffer empty.
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !start_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pack_addr_ctr.sv
// Module: pack_addr_ctr
// Holds the address of the next word to write. It returns to 0 on start and
// steps by one per written word, wrapping at 2^ADDR_W.
// Assumes the step input is asserted for one cycle per emitted word.
module pack_addr_ctr #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] cur_o
);
    logic [ADDR_W-1:0] addr_q;

    // Purpose: address for a word emitted this cycle (start restarts at 0).
    always_comb cur_o = start_i ? '0 : addr_q;

    // Purpose: advance past each written word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (step_i)
            addr_q <= cur_o + ADDR_W'(1);
        else
            addr_q <= cur_o;
    end

    // R4: every written word moves the next address on by exactly one.
    a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (addr_q == $past(cur_o) + ADDR_W'(1)));
endmodule

// File: rtl/pack_sram_drv.sv
// Module: pack_sram_drv
// Registers one write per emitted word onto the shared SRAM port, with
// active-low strobes and a port-claim select.
// Assumes emit is a single-cycle request and the data and address are valid
// in that cycle. Data and address keep their last value between writes.
module pack_sram_drv
    import packer_pkg::*;
#(
    parameter int unsigned BPW    = 4,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned WORD_W = BPW * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              held_i,
    output logic [WORD_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wen_n_o,
    output logic              cs_n_o,
    output logic              sel_o
);
    // Purpose: capture the word and its address when a write is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_data_o <= '0;
            wr_addr_o <= '0;
        end else if (emit_i) begin
            wr_data_o <= word_i;
            wr_addr_o <= addr_i;
        end
    end

    // Purpose: one-clock strobes per word, select held while work is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_n_o <= 1'b1;
            cs_n_o  <= 1'b1;
            sel_o   <= 1'b0;
        end else begin
            wen_n_o <= !emit_i;
            cs_n_o  <= !emit_i;
            sel_o   <= emit_i || held_i;
        end
    end

    // R3: no request means no strobe on the following cycle.
    a_r3_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_i |=> (cs_n_o && wen_n_o));
endmodule

// File: rtl/byte_sram_packer.sv
// Module: byte_sram_packer (top)
// Packs a byte stream into SRAM words. A partial word carries over between
// bursts, and each word is written at the next consecutive address.
// Assumes one byte per clock at most, with no back-pressure available.
module byte_sram_packer
    import packer_pkg::*;
#(
    parameter int unsigned BPW    = 4,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned WORD_W = BPW * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              flush_i,
    input  logic              byte_vld_i,
    input  logic [7:0]        byte_i,
    output logic [WORD_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wen_n_o,
    output logic              cs_n_o,
    output logic              sel_o
);
    logic              emit;
    logic [WORD_W-1:0] word;
    logic              held_nxt;
    logic [ADDR_W-1:0] cur_addr;

    pack_lane_buf #(.BPW(BPW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .flush_i   (flush_i),
        .vld_i     (byte_vld_i),
        .byte_i    (byte_i),
        .emit_o    (emit),
        .word_o    (word),
        .held_nxt_o(held_nxt)
    );

    pack_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .step_i (emit),
        .cur_o  (cur_addr)
    );

    pack_sram_drv #(.BPW(BPW), .ADDR_W(ADDR_W)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .emit_i   (emit),
        .word_i   (word),
        .addr_i   (cur_addr),
        .held_i   (held_nxt),
        .wr_data_o(wr_data_o),
        .wr_addr_o(wr_addr_o),
        .wen_n_o  (wen_n_o),
        .cs_n_o   (cs_n_o),
        .sel_o    (sel_o)
    );

    // R8: the port is claimed whenever a write strobe is on it.
    a_r8_sel_covers_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> sel_o);

    // R3: chip-select and write-enable fall and rise together.
    a_r3_strobes_agree: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o == wen_n_o);
endmodule

// File: tb/test_byte_sram_packer.sv
`timescale 1ns/1ps
module test_byte_sram_packer;
    localparam int BPW    = 4;
    localparam int ADDR_W = 4;
    localparam int WORD_W = BPW * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              flush_i = 1'b0;
    logic              byte_vld_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic [WORD_W-1:0] wr_data_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic              wen_n_o;
    logic              cs_n_o;
    logic              sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected-state bookkeeping derived from the requirements.
    int              m_cnt  = 0;
    int              m_addr = 0;
    logic [WORD_W-1:0] m_word = '0;
    int              seq = 0;

    always #2.5 clk = ~clk;

    byte_sram_packer #(.BPW(BPW), .ADDR_W(ADDR_W)) i_byte_sram_packer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .wr_data_o(wr_data_o),
        .wr_addr_o(wr_addr_o), .wen_n_o(wen_n_o), .cs_n_o(cs_n_o), .sel_o(sel_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, predict outputs, sample after the edge.
    task automatic step(input bit s, input bit f, input bit v, input string tag);
        bit          exp_wr;
        logic [7:0]  b;
        logic [WORD_W-1:0] exp_data;
        int          exp_addr;
        @(negedge clk);
        b = 8'((seq * 29 + 7) & 8'hff);
        start_i = s; flush_i = f; byte_vld_i = v; byte_i = b;
        if (v) seq++;
        exp_wr = 1'b0; exp_data = '0; exp_addr = 0;
        if (s) begin m_cnt = 0; m_word = '0; m_addr = 0; end
        if (v) begin m_word[m_cnt*8 +: 8] = b; m_cnt++; end
        if (m_cnt == BPW || (f && !s && m_cnt > 0)) begin
            exp_wr = 1'b1; exp_data = m_word; exp_addr = m_addr;
            m_addr = (m_addr + 1) % (1 << ADDR_W);
            m_cnt = 0; m_word = '0;
        end
        @(posedge clk);
        #1;
        start_i = 1'b0; flush_i = 1'b0; byte_vld_i = 1'b0;
        chk({"R3 ", tag}, "cs_n", 64'(cs_n_o), 64'(!exp_wr));
        chk({"R3 ", tag}, "wen_n", 64'(wen_n_o), 64'(!exp_wr));
        chk({"R8 ", tag}, "sel", 64'(sel_o), 64'(exp_wr || m_cnt > 0));
        if (exp_wr) begin
            chk({"R2 ", tag}, "data", 64'(wr_data_o), 64'(exp_data));
            chk({"R4 ", tag}, "addr", 64'(wr_addr_o), 64'(exp_addr));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "cs_n", 64'(cs_n_o), 64'd1);
        chk("R1", "wen_n", 64'(wen_n_o), 64'd1);
        chk("R1", "sel", 64'(sel_o), 64'd0);
        chk("R1", "addr", 64'(wr_addr_o), 64'd0);
        chk("R1", "data", 64'(wr_data_o), 64'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "cs_n after release", 64'(cs_n_o), 64'd1);
        chk("R1", "sel after release", 64'(sel_o), 64'd0);

        // R5: bursts of every length 1..9 separated by idle gaps.
        for (int len = 1; len <= 9; len++) begin
            for (int i = 0; i < len; i++) step(0, 0, 1, "R5 burst");
            for (int i = 0; i < 4; i++)   step(0, 0, 0, "R5 hold idle");
        end

        // R7: flush at every fill level, with and without a same-cycle byte.
        for (int fill = 0; fill < BPW; fill++) begin
            for (int wb = 0; wb < 2; wb++) begin
                step(1, 0, 0, "R6 restart");
                for (int i = 0; i < fill; i++) step(0, 0, 1, "R7 fill");
                step(0, 1, wb[0], "R7 flush");
                step(0, 1, 0, "R7 flush on empty");
                step(0, 0, 0, "R7 idle");
            end
        end

        // R6: start at every fill level, with a byte, then with a flush.
        for (int fill = 0; fill < BPW; fill++) begin
            for (int i = 0; i < fill; i++) step(0, 0, 1, "R6 fill");
            step(1, 0, 1, "R6 start with byte");
            for (int i = 0; i < BPW - 1; i++) step(0, 0, 1, "R6 complete");
            for (int i = 0; i < fill; i++) step(0, 0, 1, "R6 refill");
            step(1, 1, 0, "R6 start with flush");
            step(0, 0, 0, "R6 idle");
        end

        // R4: long stream past the address wrap.
        step(1, 0, 0, "R4 restart");
        for (int i = 0; i < BPW * ((1 << ADDR_W) + 3); i++) step(0, 0, 1, "R4 stream");
        step(0, 0, 0, "R4 idle");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule